// File: doc/BRIEF.md
# Two-Phase Second-Operand Latch

This block holds the second ALU operand of a 16-bit processor whose instructions come in a 16-bit short form and a 32-bit long form. The operand register is written in two half-cycles. On the first strobe it takes a full 16-bit value: either the register read bus or a 4-bit immediate from the instruction, sign-extended. On the second strobe, and only for long forms, the upper 12 bits are replaced by a field of the instruction's second half. Short forms are not changed by the second strobe.

The block also spots one instruction pattern: an add that writes the program counter from itself, using a small positive immediate. For that pattern the block doubles the latched immediate, forces its lowest bit to one and raises a carry-in request for the adder. The relative jump then reaches twice as far and gains one step. The full pattern is known only once the second half of the instruction has arrived. For this reason the shift is applied to the latch output, not to the latch input.

Top module: `opl_operand_latch`

## Requirements
- R1: After reset, `operand` is 0 and `carry_in` is 0.
- R2: A first-phase strobe (`ph1_en`) with instruction bit 1 (immediate flag) at 0 loads `rbus` into all 16 bits of the operand.
- R3: A first-phase strobe with instruction bit 1 at 1 loads instruction bits 15:12 into operand bits 3:0, and fills operand bits 15:4 with copies of instruction bit 15.
- R4: A second-phase strobe (`ph2_en`) with instruction bit 0 (long flag) at 0 leaves the operand unchanged.
- R5: A second-phase strobe with instruction bits 1:0 = 01 loads instruction bits 27:16 into operand bits 15:4 and keeps bits 3:0.
- R6: A second-phase strobe with instruction bits 1:0 = 11 loads instruction bits 17:16 into operand bits 5:4, fills bits 15:6 with copies of instruction bit 17, and keeps bits 3:0.
- R7: With neither strobe high, `operand` and `carry_in` hold their values whatever the other inputs do.
- R8: The extension takes effect after a second-phase strobe if all of the following hold at that strobe: `opcode` equals the add code (default 1); instruction bits 1:0 = 11; source address bits 7:4 = 0; destination address bits 11:8 = 0; instruction bit 20 = 1; instruction bit 17 (the sign of the 6-bit immediate) = 0. While it is in effect, `carry_in` is 1 and `operand` equals the latched value shifted left by one with bit 0 set to 1.
- R9: If any one of the R8 conditions fails, `carry_in` is 0 and `operand` is the latched value unmodified.
- R10: A first-phase strobe cancels any active extension.
- R11: When both strobes are high in the same cycle, only the first-phase action takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ph1_en | input | 1 | First half-cycle load strobe |
| ph2_en | input | 1 | Second half-cycle load strobe |
| opcode | input | 5 | Decoded operation code of the current instruction |
| insn | input | 32 | Current instruction word (upper half meaningful for long forms) |
| rbus | input | 16 | Register file read bus for the second operand |
| operand | output | 16 | Operand presented to the ALU |
| carry_in | output | 1 | Carry-in request to the adder for the range extension |

## Verification
On every cycle, the assertions check the following: each strobe's effect on the latched value for all four combinations of form flags; that the operand is held when no strobe is high; that an asserted carry always comes with the shifted, bit-zero-set shape; and that a first-phase strobe always drops the carry. Only the bench scenarios can show when the extension actually turns on. They do this by taking the six trigger conditions one at a time, and by checking exact operand values in the reset state and after the two strobes arrive together.

// File: rtl/opl_pkg.sv
package opl_pkg;
  // Instruction field positions (behaviour depends on these)
  localparam int LONG_FLAG_BIT = 0;
  localparam int IMM_FLAG_BIT  = 1;
  localparam int SRC_LSB       = 4;
  localparam int DST_LSB       = 8;
  localparam int ADDR_W        = 4;
  localparam int NIB_LSB       = 12;
  localparam int LONG_LSB      = 16;
  localparam int AUX_BIT       = 20;
  localparam int SHORT_IMM_W   = 2;   // width of long-immediate bits above the nibble

  typedef enum logic [1:0] {
    HI_FROM_BUS      = 2'b00,
    HI_FROM_NIB_SIGN = 2'b01,
    HI_FROM_FIELD    = 2'b10,
    HI_FROM_LONG_IMM = 2'b11
  } hi_sel_e;

  typedef struct packed {
    logic is_long;
    logic is_imm;
  } form_t;

  function automatic form_t decode_form(input logic [1:0] low2);
    form_t f;
    f.is_long = low2[LONG_FLAG_BIT];
    f.is_imm  = low2[IMM_FLAG_BIT];
    return f;
  endfunction
endpackage

// File: rtl/opl_rst_sync.sv
module opl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/opl_lo_mux.sv
module opl_lo_mux #(
  parameter int NIB_W = 4
) (
  input  logic             is_imm,
  input  logic [NIB_W-1:0] bus_lo,
  input  logic [NIB_W-1:0] insn_nib,
  output logic [NIB_W-1:0] lo_val
);
  always_comb begin
    lo_val = is_imm ? insn_nib : bus_lo;
  end
endmodule

// File: rtl/opl_hi_mux.sv
module opl_hi_mux #(
  parameter int HI_W   = 12,
  parameter int NARROW = 2
) (
  input  opl_pkg::hi_sel_e sel,
  input  logic [HI_W-1:0]  bus_hi,
  input  logic             nib_sign,
  input  logic [HI_W-1:0]  long_field,
  output logic [HI_W-1:0]  hi_val
);
  import opl_pkg::*;

  logic [HI_W-1:0] long_imm_ext;

  // Narrow long immediate: low NARROW bits taken, the rest copy its top bit
  for (genvar i = 0; i < HI_W; i++) begin : g_ext
    if (i < NARROW) begin : g_keep
      assign long_imm_ext[i] = long_field[i];
    end else begin : g_sign
      assign long_imm_ext[i] = long_field[NARROW-1];
    end
  end

  always_comb begin
    unique case (sel)
      HI_FROM_BUS:      hi_val = bus_hi;
      HI_FROM_NIB_SIGN: hi_val = {HI_W{nib_sign}};
      HI_FROM_FIELD:    hi_val = long_field;
      HI_FROM_LONG_IMM: hi_val = long_imm_ext;
      default:          hi_val = bus_hi;
    endcase
  end
endmodule

// File: rtl/opl_ext_detect.sv
module opl_ext_detect #(
  parameter int               OP_W    = 5,
  parameter logic [OP_W-1:0]  OPC_ADD = 5'h01,
  parameter int               ADDR_W  = 4
) (
  input  logic [OP_W-1:0]   opcode,
  input  logic [1:0]        form_bits,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic              aux_flag,
  input  logic              imm_sign,
  output logic              hit
);
  logic is_add;
  logic pc_src;
  logic pc_dst;
  logic ext_form;

  always_comb begin
    is_add   = (opcode == OPC_ADD);
    ext_form = (form_bits == 2'b11);
    pc_src   = (src_addr == '0);
    pc_dst   = (dst_addr == '0);
    hit      = is_add && ext_form && pc_src && pc_dst && aux_flag && !imm_sign;
  end
endmodule

// File: rtl/opl_operand_latch.sv
module opl_operand_latch #(
  parameter int               DATA_W  = 16,
  parameter int               INSN_W  = 32,
  parameter int               OP_W    = 5,
  parameter logic [OP_W-1:0]  OPC_ADD = 5'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ph1_en,
  input  logic              ph2_en,
  input  logic [OP_W-1:0]   opcode,
  input  logic [INSN_W-1:0] insn,
  input  logic [DATA_W-1:0] rbus,
  output logic [DATA_W-1:0] operand,
  output logic              carry_in
);
  import opl_pkg::*;

  localparam int NIB_W    = 4;
  localparam int HI_W     = DATA_W - NIB_W;
  localparam int FIELD_HI = LONG_LSB + HI_W - 1;
  localparam int IMM_SIGN = LONG_LSB + SHORT_IMM_W - 1;

  logic              rst_sync_n;
  form_t             form;
  hi_sel_e           sel_ph1;
  hi_sel_e           sel_ph2;
  logic [NIB_W-1:0]  lo_ph1;
  logic [HI_W-1:0]   hi_ph1;
  logic [HI_W-1:0]   hi_ph2;
  logic              ext_hit;
  logic [DATA_W-1:0] lat_q, lat_d;
  logic              ext_q, ext_d;
  logic              load_en;
  logic [INSN_W-1:FIELD_HI+1] unused_insn_hi;
  logic [3:2]        unused_insn_lo;

  assign unused_insn_hi = insn[INSN_W-1:FIELD_HI+1];
  assign unused_insn_lo = insn[3:2];

  opl_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    form    = decode_form(insn[1:0]);
    sel_ph1 = form.is_imm ? HI_FROM_NIB_SIGN : HI_FROM_BUS;
    sel_ph2 = form.is_imm ? HI_FROM_LONG_IMM : HI_FROM_FIELD;
  end

  opl_lo_mux #(.NIB_W(NIB_W)) u_lo_mux (
    .is_imm   (form.is_imm),
    .bus_lo   (rbus[NIB_W-1:0]),
    .insn_nib (insn[NIB_LSB +: NIB_W]),
    .lo_val   (lo_ph1)
  );

  opl_hi_mux #(.HI_W(HI_W), .NARROW(SHORT_IMM_W)) u_hi_mux_ph1 (
    .sel        (sel_ph1),
    .bus_hi     (rbus[DATA_W-1:NIB_W]),
    .nib_sign   (insn[NIB_LSB+NIB_W-1]),
    .long_field (insn[FIELD_HI:LONG_LSB]),
    .hi_val     (hi_ph1)
  );

  opl_hi_mux #(.HI_W(HI_W), .NARROW(SHORT_IMM_W)) u_hi_mux_ph2 (
    .sel        (sel_ph2),
    .bus_hi     (rbus[DATA_W-1:NIB_W]),
    .nib_sign   (insn[NIB_LSB+NIB_W-1]),
    .long_field (insn[FIELD_HI:LONG_LSB]),
    .hi_val     (hi_ph2)
  );

  opl_ext_detect #(.OP_W(OP_W), .OPC_ADD(OPC_ADD), .ADDR_W(ADDR_W)) u_ext_detect (
    .opcode    (opcode),
    .form_bits (insn[1:0]),
    .src_addr  (insn[SRC_LSB +: ADDR_W]),
    .dst_addr  (insn[DST_LSB +: ADDR_W]),
    .aux_flag  (insn[AUX_BIT]),
    .imm_sign  (insn[IMM_SIGN]),
    .hit       (ext_hit)
  );

  // Next-state: phase 1 wins over phase 2
  always_comb begin
    load_en = ph1_en || ph2_en;
    lat_d   = lat_q;
    ext_d   = ext_q;
    if (ph1_en) begin
      lat_d = {hi_ph1, lo_ph1};
      ext_d = 1'b0;
    end else if (ph2_en) begin
      if (form.is_long) begin
        lat_d[DATA_W-1:NIB_W] = hi_ph2;
      end
      ext_d = ext_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lat_q <= '0;
      ext_q <= 1'b0;
    end else if (load_en) begin
      lat_q <= lat_d;
      ext_q <= ext_d;
    end
  end

  // Post-latch doubling with forced low bit
  always_comb begin
    operand  = ext_q ? {lat_q[DATA_W-2:0], 1'b1} : lat_q;
    carry_in = ext_q;
  end
endmodule

// File: rtl/opl_operand_latch_chk.sv
module opl_operand_latch_chk #(
  parameter int DATA_W = 16,
  parameter int INSN_W = 32
) (
  input logic              clk,
  input logic              rst_ok_n,
  input logic              ph1_en,
  input logic              ph2_en,
  input logic [INSN_W-1:0] insn,
  input logic [DATA_W-1:0] rbus,
  input logic [DATA_W-1:0] lat_q,
  input logic [DATA_W-1:0] operand,
  input logic              carry_in
);
  localparam int NIB_W = 4;
  localparam int HI_W  = DATA_W - NIB_W;

  logic [INSN_W-1:28] unused_chk_hi;
  logic [11:2]        unused_chk_mid;
  assign unused_chk_hi  = insn[INSN_W-1:28];
  assign unused_chk_mid = insn[11:2];

  assert_bus_load_R2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (ph1_en && !insn[1]) |=> (operand == $past(rbus)) && !carry_in);

  assert_short_imm_R3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (ph1_en && insn[1]) |=>
      (operand == {{HI_W{$past(insn[15])}}, $past(insn[15:12])}) && !carry_in);

  assert_short_ignored_R4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (ph2_en && !ph1_en && !insn[0]) |=> $stable(lat_q));

  assert_long_field_R5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (ph2_en && !ph1_en && insn[1:0] == 2'b01) |=>
      (lat_q[DATA_W-1:NIB_W] == $past(insn[27:16])) && $stable(lat_q[NIB_W-1:0]));

  assert_long_imm_R6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (ph2_en && !ph1_en && insn[1:0] == 2'b11) |=>
      (lat_q[DATA_W-1:NIB_W] == {{(HI_W-2){$past(insn[17])}}, $past(insn[17:16])})
      && $stable(lat_q[NIB_W-1:0]));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!ph1_en && !ph2_en) |=> $stable(operand) && $stable(carry_in));

  assert_ext_shape_R8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    carry_in |-> operand[0] && (operand[DATA_W-1:1] == lat_q[DATA_W-2:0]));

  assert_passthrough_R9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !carry_in |-> (operand == lat_q));

  assert_ph1_clears_R10: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ph1_en |=> !carry_in);
endmodule

bind opl_operand_latch opl_operand_latch_chk #(.DATA_W(DATA_W), .INSN_W(INSN_W)) u_chk (
  .clk      (clk),
  .rst_ok_n (rst_sync_n),
  .ph1_en   (ph1_en),
  .ph2_en   (ph2_en),
  .insn     (insn),
  .rbus     (rbus),
  .lat_q    (lat_q),
  .operand  (operand),
  .carry_in (carry_in)
);

// File: tb/opl_operand_latch_test.sv
module opl_operand_latch_test;
  logic        clk;
  logic        rst_n;
  logic        ph1_en, ph2_en;
  logic [4:0]  opcode;
  logic [31:0] insn;
  logic [15:0] rbus;
  logic [15:0] operand;
  logic        carry_in;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  localparam logic [4:0] ADD = 5'h01;

  opl_operand_latch uut (
    .clk(clk), .rst_n(rst_n), .ph1_en(ph1_en), .ph2_en(ph2_en),
    .opcode(opcode), .insn(insn), .rbus(rbus),
    .operand(operand), .carry_in(carry_in)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic logic [31:0] mk(input logic sl, input logic ir,
      input logic [3:0] src, input logic [3:0] dst, input logic [3:0] nib,
      input logic [15:0] up);
    return {up, nib, dst, src, 2'b00, ir, sl};
  endfunction

  task automatic chk(input string req, input logic [15:0] eo, input logic ec);
    n_checks++;
    if (operand !== eo || carry_in !== ec) begin
      n_errors++;
      $display("FAIL %s: operand=%h carry=%b expected operand=%h carry=%b",
               req, operand, carry_in, eo, ec);
    end
  endtask

  // One clock with the given strobes; results sampled at the following negedge
  task automatic cyc(input logic p1, input logic p2, input logic [4:0] op,
                     input logic [31:0] ins, input logic [15:0] bus);
    @(negedge clk);
    ph1_en = p1; ph2_en = p2; opcode = op; insn = ins; rbus = bus;
    @(posedge clk);
    @(negedge clk);
    ph1_en = 0; ph2_en = 0;
  endtask

  task automatic t_reset;
    chk("R1 reset", 16'h0000, 1'b0);
  endtask

  task automatic t_bus_and_short;
    cyc(1, 0, 5'h00, mk(0, 0, 4'h2, 4'h3, 4'h0, 16'h0000), 16'hA5C3);
    chk("R2 bus load", 16'hA5C3, 1'b0);
    cyc(0, 1, 5'h00, mk(0, 0, 4'h2, 4'h3, 4'h0, 16'hFFFF), 16'h0000);
    chk("R4 short phase2 ignored", 16'hA5C3, 1'b0);
    cyc(1, 0, ADD, mk(0, 1, 4'h0, 4'h0, 4'h9, 16'h0000), 16'h1234);
    chk("R3 short imm negative", 16'hFFF9, 1'b0);
    cyc(0, 1, ADD, mk(0, 1, 4'h0, 4'h0, 4'h9, 16'h0013), 16'h1234);
    chk("R4 short imm phase2 ignored", 16'hFFF9, 1'b0);
    cyc(1, 0, 5'h00, mk(0, 1, 4'h1, 4'h1, 4'h7, 16'h0000), 16'hFFFF);
    chk("R3 short imm positive", 16'h0007, 1'b0);
  endtask

  task automatic t_long_forms;
    cyc(1, 0, 5'h00, mk(1, 0, 4'h1, 4'h2, 4'h0, 16'h0ABC), 16'h1234);
    chk("R2 long form phase1", 16'h1234, 1'b0);
    cyc(0, 1, 5'h00, mk(1, 0, 4'h1, 4'h2, 4'h0, 16'h0ABC), 16'h0000);
    chk("R5 long field", 16'hABC4, 1'b0);
    cyc(1, 0, 5'h00, mk(1, 1, 4'h1, 4'h2, 4'h5, 16'h0002), 16'hFFFF);
    chk("R3 long imm phase1", 16'h0005, 1'b0);
    cyc(0, 1, 5'h00, mk(1, 1, 4'h1, 4'h2, 4'h5, 16'h0002), 16'hFFFF);
    chk("R6 long imm negative", 16'hFFE5, 1'b0);
    cyc(1, 0, 5'h00, mk(1, 1, 4'h1, 4'h2, 4'hC, 16'h0001), 16'h0000);
    cyc(0, 1, 5'h00, mk(1, 1, 4'h1, 4'h2, 4'hC, 16'hFF01), 16'h0000);
    chk("R6 long imm positive", 16'h001C, 1'b0);
  endtask

  // Base trigger: long imm, pc src/dst, aux=1, sign=0, bit16=1, nib=3 -> latched 0x0013
  task automatic run_ext(input logic [4:0] op, input logic [31:0] ins, input logic [15:0] bus);
    cyc(1, 0, op, ins, bus);
    cyc(0, 1, op, ins, bus);
  endtask

  task automatic t_ext;
    run_ext(ADD, mk(1, 1, 4'h0, 4'h0, 4'h3, 16'h0011), 16'h0000);
    chk("R8 extension active", 16'h0027, 1'b1);
    @(negedge clk);
    opcode = 5'h1F; insn = 32'hFFFF_FFFF; rbus = 16'hFFFF;
    @(negedge clk);
    chk("R7 hold while extended", 16'h0027, 1'b1);
    cyc(1, 0, 5'h00, mk(0, 0, 4'h5, 4'h5, 4'h0, 16'h0000), 16'h0F0F);
    chk("R10 phase1 clears extension", 16'h0F0F, 1'b0);
  endtask

  task automatic t_ext_miss;
    run_ext(5'h02, mk(1, 1, 4'h0, 4'h0, 4'h3, 16'h0011), 16'h0000);
    chk("R9 opcode not add", 16'h0013, 1'b0);
    run_ext(ADD, mk(1, 1, 4'h1, 4'h0, 4'h3, 16'h0011), 16'h0000);
    chk("R9 source not pc", 16'h0013, 1'b0);
    run_ext(ADD, mk(1, 1, 4'h0, 4'h4, 4'h3, 16'h0011), 16'h0000);
    chk("R9 destination not pc", 16'h0013, 1'b0);
    run_ext(ADD, mk(1, 1, 4'h0, 4'h0, 4'h3, 16'h0001), 16'h0000);
    chk("R9 aux flag clear", 16'h0013, 1'b0);
    run_ext(ADD, mk(1, 1, 4'h0, 4'h0, 4'h3, 16'h0013), 16'h0000);
    chk("R9 negative imm6", 16'hFFF3, 1'b0);
    run_ext(ADD, mk(1, 0, 4'h0, 4'h0, 4'h3, 16'h0011), 16'h5A5A);
    chk("R9 register form", 16'h011A, 1'b0);
    run_ext(ADD, mk(0, 1, 4'h0, 4'h0, 4'h3, 16'h0011), 16'h0000);
    chk("R9 short form", 16'h0003, 1'b0);
  endtask

  task automatic t_both_and_hold;
    cyc(1, 1, 5'h00, mk(1, 0, 4'h1, 4'h1, 4'h0, 16'h0ABC), 16'h1111);
    chk("R11 both strobes", 16'h1111, 1'b0);
    @(negedge clk);
    opcode = ADD; insn = mk(1, 1, 4'h0, 4'h0, 4'h3, 16'h0011); rbus = 16'h7777;
    @(negedge clk);
    @(negedge clk);
    chk("R7 hold without strobes", 16'h1111, 1'b0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 0; ph1_en = 0; ph2_en = 0; opcode = 0; insn = 0; rbus = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bus_and_short();
    t_long_forms();
    t_ext();
    t_ext_miss();
    t_both_and_hold();
    finish_run();
  end
endmodule